// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM and owns the command pins: chip select, row strobe, column strobe, write enable, the address bus and the bank bits. After reset it runs the fixed start-up order. It first issues a long stretch of NOPs. It then closes every bank with a precharge, issues two auto refreshes and loads the mode register with a word fixed at build time. Each wait in this order is a cycle count set by a parameter, so a designer converts each time limit by dividing it by the clock period and rounding up.

Once the mode-load delay has passed, `init_done` rises. From then on the block gives a requester one-cycle grants to issue ACTIVE, READ, WRITE or BURST TERMINATE commands, and the block passes each granted command to the pins one cycle later. A refresh-interval counter raises a pending refresh at a fixed period. A pending refresh takes priority: the grant is withdrawn, all banks are precharged, the precharge time is waited out, an AUTO REFRESH is issued, and the grant comes back only after the refresh-cycle time.

States: `ST_PWRUP` (NOP wait) → `ST_I_PRE` → `ST_I_PRE_W` → `ST_I_REF1` → `ST_I_REF1_W` → `ST_I_REF2` → `ST_I_REF2_W` → `ST_I_MODE` → `ST_I_MODE_W` → `ST_SERVE`. From `ST_SERVE`, a pending refresh leads to `ST_R_PRE` → `ST_R_PRE_W` → `ST_R_REF` → `ST_R_REF_W` → back to `ST_SERVE`. Each issue state lasts one cycle. Each wait state leaves when the delay timer reaches zero.

Top module: `sdr_init_refresh`

## Requirements
- R1: While reset is held and for exactly PWRUP_CYC cycles after its release, the pins carry NOP, `init_done` is low and `grant` is low.
- R2: The first command is PRECHARGE with address bit AP_BIT high (all banks). An AUTO REFRESH follows exactly TRP_CYC cycles later, and a second AUTO REFRESH follows exactly TRC_CYC cycles after the first.
- R3: LOAD MODE follows the second refresh by exactly TRC_CYC cycles, and during it {bank, address} equals MODE_WORD.
- R4: `init_done` rises exactly TMRD_CYC cycles after LOAD MODE is on the pins and then stays high. LOAD MODE is never issued again.
- R5: The pin codes for {cs_n, ras_n, cas_n, we_n} are: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, BURST TERMINATE 0110, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R6: `grant` is high only when `init_done` is high, the sequencer is idle and no refresh is pending. A request with `req_valid` high while `grant` is high appears on the pins in the next cycle with its bank and address, where `req_op` 0=ACTIVE, 1=READ, 2=WRITE, 3=BURST TERMINATE. A request while `grant` is low has no effect on the pins.
- R7: After initialization, an AUTO REFRESH is issued every REFI_CYC cycles. Each one is preceded, exactly TRP_CYC cycles earlier, by a PRECHARGE with address bit AP_BIT high.
- R8: A request held valid through a refresh reaches the pins exactly TRC_CYC cycles after the AUTO REFRESH.
- R9: No command other than NOP appears fewer than TRP_CYC cycles after a PRECHARGE, or fewer than TRC_CYC cycles after an AUTO REFRESH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and the command pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester wants to issue a command this cycle |
| req_op | input | 2 | Requested command: 0 ACTIVE, 1 READ, 2 WRITE, 3 BURST TERMINATE |
| req_bank | input | BA_W | Bank for the requested command |
| req_addr | input | ADDR_W | Row or column (with auto-precharge bit) for the request |
| grant | output | 1 | Request accepted this cycle |
| init_done | output | 1 | Start-up order complete and mode-load delay met |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank bits to the SDRAM |
| sd_addr | output | ADDR_W | Address bus to the SDRAM |

## Verification
The bound checker watches every cycle for the following: a grant before initialization is done, `init_done` falling after it has risen, a LOAD MODE after start-up or with the wrong word, a command inside the precharge or refresh-cycle window, and refresh commands spaced differently from the set interval. It also checks that `init_done` rises exactly the mode-load delay after LOAD MODE. Only the bench scenarios can show the exact NOP count after reset, the exact command order and spacing during start-up, that granted requests reach the pins one cycle later with their own bank and address, that requests made while the grant is withdrawn leave no trace on the pins, and that a waiting requester resumes exactly one refresh-cycle time after the refresh.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Pin code ordered {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_BST  = 4'b0110,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_I_PRE,
        ST_I_PRE_W,
        ST_I_REF1,
        ST_I_REF1_W,
        ST_I_REF2,
        ST_I_REF2_W,
        ST_I_MODE,
        ST_I_MODE_W,
        ST_SERVE,
        ST_R_PRE,
        ST_R_PRE_W,
        ST_R_REF,
        ST_R_REF_W
    } seq_state_e;

    function automatic sdr_cmd_e op_to_cmd(input logic [1:0] op);
        unique case (op)
            2'd0:    return CMD_ACT;
            2'd1:    return CMD_RD;
            2'd2:    return CMD_WR;
            default: return CMD_BST;
        endcase
    endfunction

endpackage

// File: rtl/sdr_delay_timer.sv
module sdr_delay_timer #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_tick.sv
module sdr_refresh_tick #(
    parameter int unsigned REFI_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic pend
);
    localparam int unsigned CW = $clog2(REFI_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(REFI_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          fire;

    assign fire = en && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
            pend  <= 1'b0;
        end else begin
            if (en) begin
                cnt_q <= fire ? RELOAD : cnt_q - 1'b1;
            end
            pend <= (pend && !clr) || fire;
        end
    end
endmodule

// File: rtl/sdr_pin_reg.sv
module sdr_pin_reg
    import sdr_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned BA_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdr_cmd_e          cmd_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [BA_W-1:0]   ba_d,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    logic [3:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= CMD_NOP;
            addr   <= '0;
            ba     <= '0;
        end else begin
            code_q <= cmd_d;
            addr   <= addr_d;
            ba     <= ba_d;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = code_q;
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BA_W      = 1,
    parameter int unsigned AP_BIT    = 10,
    parameter int unsigned PWRUP_CYC = 5000,
    parameter int unsigned TRP_CYC   = 3,
    parameter int unsigned TRC_CYC   = 4,
    parameter int unsigned TMRD_CYC  = 2,
    parameter int unsigned REFI_CYC  = 780,
    parameter int unsigned MODE_WORD = 'h023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              grant,
    output logic              init_done,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);
    localparam int unsigned MW    = ADDR_W + BA_W;
    localparam int unsigned T_A   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int unsigned T_B   = (T_A > TMRD_CYC) ? T_A : TMRD_CYC;
    localparam int unsigned T_MAX = (T_B > PWRUP_CYC) ? T_B : PWRUP_CYC;
    localparam int unsigned TW    = $clog2(T_MAX + 1);

    localparam logic [TW-1:0]     PWRUP_LD = TW'(PWRUP_CYC - 1);
    localparam logic [TW-1:0]     TRP_LD   = TW'(TRP_CYC - 2);
    localparam logic [TW-1:0]     TRC_LD   = TW'(TRC_CYC - 2);
    localparam logic [TW-1:0]     TMRD_LD  = TW'(TMRD_CYC - 2);
    localparam logic [MW-1:0]     MODE_BITS = MW'(MODE_WORD);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

    seq_state_e        state_q, state_d;
    logic              t_load, t_zero;
    logic [TW-1:0]     t_val;
    logic              ref_pend, ref_clr;
    logic              done_q;
    sdr_cmd_e          cmd_d;
    logic [ADDR_W-1:0] addr_d;
    logic [BA_W-1:0]   ba_d;

    sdr_delay_timer #(
        .W       (TW),
        .RST_VAL (PWRUP_LD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sdr_refresh_tick #(
        .REFI_CYC (REFI_CYC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (done_q),
        .clr   (ref_clr),
        .pend  (ref_pend)
    );

    sdr_pin_reg #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_d  (cmd_d),
        .addr_d (addr_d),
        .ba_d   (ba_d),
        .cs_n   (sd_cs_n),
        .ras_n  (sd_ras_n),
        .cas_n  (sd_cas_n),
        .we_n   (sd_we_n),
        .addr   (sd_addr),
        .ba     (sd_ba)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SERVE) begin
                done_q <= 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:    if (t_zero) state_d = ST_I_PRE;
            ST_I_PRE:    state_d = ST_I_PRE_W;
            ST_I_PRE_W:  if (t_zero) state_d = ST_I_REF1;
            ST_I_REF1:   state_d = ST_I_REF1_W;
            ST_I_REF1_W: if (t_zero) state_d = ST_I_REF2;
            ST_I_REF2:   state_d = ST_I_REF2_W;
            ST_I_REF2_W: if (t_zero) state_d = ST_I_MODE;
            ST_I_MODE:   state_d = ST_I_MODE_W;
            ST_I_MODE_W: if (t_zero) state_d = ST_SERVE;
            ST_SERVE:    if (ref_pend) state_d = ST_R_PRE;
            ST_R_PRE:    state_d = ST_R_PRE_W;
            ST_R_PRE_W:  if (t_zero) state_d = ST_R_REF;
            ST_R_REF:    state_d = ST_R_REF_W;
            ST_R_REF_W:  if (t_zero) state_d = ST_SERVE;
            default:     state_d = ST_PWRUP;
        endcase
    end

    // Outputs: next pin values, timer loads, refresh clear
    always_comb begin
        cmd_d   = CMD_NOP;
        addr_d  = '0;
        ba_d    = '0;
        t_load  = 1'b0;
        t_val   = '0;
        ref_clr = 1'b0;
        unique case (state_q)
            ST_I_PRE, ST_R_PRE: begin
                cmd_d  = CMD_PRE;
                addr_d = ALL_BANKS;
                t_load = 1'b1;
                t_val  = TRP_LD;
            end
            ST_I_REF1, ST_I_REF2, ST_R_REF: begin
                cmd_d   = CMD_REF;
                t_load  = 1'b1;
                t_val   = TRC_LD;
                ref_clr = (state_q == ST_R_REF);
            end
            ST_I_MODE: begin
                cmd_d          = CMD_LMR;
                {ba_d, addr_d} = MODE_BITS;
                t_load         = 1'b1;
                t_val          = TMRD_LD;
            end
            ST_SERVE: begin
                if (!ref_pend && done_q && req_valid) begin
                    cmd_d  = op_to_cmd(req_op);
                    addr_d = req_addr;
                    ba_d   = req_bank;
                end
            end
            default: begin
                cmd_d = CMD_NOP;
            end
        endcase
    end

    assign grant     = done_q && (state_q == ST_SERVE) && !ref_pend;
    assign init_done = done_q;
endmodule

// File: rtl/sdr_init_refresh_chk.sv
module sdr_init_refresh_chk #(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BA_W      = 1,
    parameter int unsigned TRP_CYC   = 3,
    parameter int unsigned TRC_CYC   = 4,
    parameter int unsigned TMRD_CYC  = 2,
    parameter int unsigned REFI_CYC  = 780,
    parameter int unsigned MODE_WORD = 'h023
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant,
    input logic              init_done,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr
);
    localparam int unsigned PW = $clog2(TRP_CYC + 2);
    localparam int unsigned RW = $clog2(TRC_CYC + 2);
    localparam int unsigned MWD = $clog2(TMRD_CYC + 2);
    localparam int unsigned IW = $clog2(REFI_CYC + 2);
    localparam logic [ADDR_W+BA_W-1:0] MODE_BITS = (ADDR_W+BA_W)'(MODE_WORD);

    logic [3:0] code;
    logic       busy_cmd, is_pre, is_ref, is_lmr;
    assign code     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign busy_cmd = (code != 4'b0111);
    assign is_pre   = (code == 4'b0010);
    assign is_ref   = (code == 4'b0001);
    assign is_lmr   = (code == 4'b0000);

    logic [PW-1:0]  since_pre;
    logic [RW-1:0]  since_ref;
    logic [MWD-1:0] since_lmr;
    logic [IW-1:0]  refi_cnt;
    logic           run_ref_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_pre    <= '0;
            since_ref    <= '0;
            since_lmr    <= '0;
            refi_cnt     <= '0;
            run_ref_seen <= 1'b0;
        end else begin
            if (is_pre) since_pre <= PW'(1);
            else if (since_pre != '0 && since_pre < PW'(TRP_CYC)) since_pre <= since_pre + 1'b1;
            if (is_ref) since_ref <= RW'(1);
            else if (since_ref != '0 && since_ref < RW'(TRC_CYC)) since_ref <= since_ref + 1'b1;
            if (is_lmr) since_lmr <= MWD'(1);
            else if (since_lmr != '0 && since_lmr <= MWD'(TMRD_CYC)) since_lmr <= since_lmr + 1'b1;
            if (is_ref && init_done) begin
                refi_cnt     <= IW'(1);
                run_ref_seen <= 1'b1;
            end else if (refi_cnt != '0 && refi_cnt <= IW'(REFI_CYC)) begin
                refi_cnt <= refi_cnt + 1'b1;
            end
        end
    end

    // R6
    grant_needs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> init_done);

    // R4
    init_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R4
    mode_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |-> !init_done);

    // R4
    mode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (since_lmr == MWD'(TMRD_CYC)));

    // R3
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |-> ({sd_ba, sd_addr} == MODE_BITS));

    // R9
    trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cmd && since_pre != '0) |-> (since_pre >= PW'(TRP_CYC)));

    // R9
    trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cmd && since_ref != '0) |-> (since_ref >= RW'(TRC_CYC)));

    // R7
    refresh_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && init_done && run_ref_seen) |-> (refi_cnt == IW'(REFI_CYC)));
endmodule

bind sdr_init_refresh sdr_init_refresh_chk #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .TRP_CYC   (TRP_CYC),
    .TRC_CYC   (TRC_CYC),
    .TMRD_CYC  (TMRD_CYC),
    .REFI_CYC  (REFI_CYC),
    .MODE_WORD (MODE_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .init_done (init_done),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr)
);

// File: tb/test_sdr_init_refresh.sv
module test_sdr_init_refresh;
    localparam int ADDR_W = 11;
    localparam int BA_W   = 1;
    localparam int AP_BIT = 10;
    localparam int PWRUP  = 20;
    localparam int TRP    = 3;
    localparam int TRC    = 5;
    localparam int TMRD   = 2;
    localparam int REFI   = 40;
    localparam int MODE   = 'h823;

    // R5 pin codes {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] E_NOP = 4'b0111, E_ACT = 4'b0011, E_RD  = 4'b0101,
                           E_WR  = 4'b0100, E_BST = 4'b0110, E_PRE = 4'b0010,
                           E_REF = 4'b0001, E_LMR = 4'b0000;

    typedef struct {
        logic [3:0]        code;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        int                gap;
        string             req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [BA_W-1:0] req_bank = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic grant, init_done, cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;

    int checks = 0, errors = 0;
    exp_t q[$];
    bit cont_phase = 0;
    int n_run_refs = 0;

    always #10 clk = ~clk;

    sdr_init_refresh #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .PWRUP_CYC(PWRUP),
        .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD), .REFI_CYC(REFI),
        .MODE_WORD(MODE)
    ) i_sdr_init_refresh (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .grant(grant),
        .init_done(init_done), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
        .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [3:0] op_code(input int op);
        case (op)
            0: return E_ACT;
            1: return E_RD;
            2: return E_WR;
            default: return E_BST;
        endcase
    endfunction

    task automatic push(input logic [3:0] c, input logic [BA_W-1:0] b,
                        input logic [ADDR_W-1:0] a, input int g, input string r);
        exp_t e;
        e.code = c; e.ba = b; e.addr = a; e.gap = g; e.req = r;
        q.push_back(e);
    endtask

    // Monitor / scoreboard
    initial begin
        int since = 0, tick = 0, lmr_tick = -1, last_ref = -1;
        bit mode_seen = 0, prev_done = 0, last_was_ref = 0, last_was_pre = 0;
        logic [3:0] c;
        exp_t e;
        @(negedge clk);
        // R1 reset state
        chk({cs_n, ras_n, cas_n, we_n} == E_NOP, "R1", "pins during reset",
            {cs_n, ras_n, cas_n, we_n}, E_NOP);
        chk(!init_done && !grant, "R1", "done/grant during reset",
            {init_done, grant}, 0);
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            since++; tick++;
            c = {cs_n, ras_n, cas_n, we_n};
            if (init_done && !prev_done) begin
                chk(tick - lmr_tick == TMRD, "R4", "init_done delay after mode load",
                    tick - lmr_tick, TMRD);
            end
            if (prev_done && !init_done)
                chk(0, "R4", "init_done fell", 0, 1);
            prev_done = init_done;
            if (grant && !init_done) chk(0, "R6", "grant before init", 1, 0);
            if (c != E_NOP) begin
                if (!mode_seen || !(c == E_PRE || c == E_REF || c == E_LMR)) begin
                    if (mode_seen && last_was_ref && cont_phase)
                        chk(since == TRC, "R8", "resume after refresh", since, TRC);
                    if (q.size() == 0) begin
                        chk(0, "R6", "unexpected command code", c, E_NOP);
                    end else begin
                        e = q.pop_front();
                        chk(c == e.code, e.req, "command code", c, e.code);
                        chk(sd_addr == e.addr && sd_ba == e.ba, e.req, "bank/address",
                            {sd_ba, sd_addr}, {e.ba, e.addr});
                        if (e.gap >= 0)
                            chk(since == e.gap, e.req, "cycle spacing", since, e.gap);
                    end
                    if (c == E_LMR) begin
                        mode_seen = 1;
                        lmr_tick = tick;
                    end
                    last_was_pre = 0;
                end else if (c == E_LMR) begin
                    chk(0, "R4", "mode load repeated", c, E_NOP);
                end else if (c == E_PRE) begin
                    chk(sd_addr[AP_BIT] == 1'b1, "R7", "refresh precharge all-bank bit",
                        sd_addr[AP_BIT], 1);
                    last_was_pre = 1;
                end else begin
                    chk(last_was_pre && since == TRP, "R7", "precharge to refresh spacing",
                        since, TRP);
                    if (last_ref >= 0)
                        chk(tick - last_ref == REFI, "R7", "refresh interval",
                            tick - last_ref, REFI);
                    last_ref = tick;
                    n_run_refs++;
                    last_was_pre = 0;
                end
                last_was_ref = (c == E_REF);
                since = 0;
            end
        end
    end

    // Driver
    initial begin
        push(E_PRE, '0, 11'h400, PWRUP + 1, "R1");
        push(E_REF, '0, '0, TRP, "R2");
        push(E_REF, '0, '0, TRC, "R2");
        push(E_LMR, MODE[ADDR_W +: BA_W], MODE[ADDR_W-1:0], TRC, "R3");
        repeat (4) @(negedge clk);
        #5 rst_n = 1'b1;
        wait (init_done === 1'b1);

        // Single requests, one per op
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            while (!grant) @(negedge clk);
            req_valid = 1'b1; req_op = 2'(k);
            req_bank = 1'(k); req_addr = 11'(11'h2A5 + k * 11'h111);
            push(op_code(k), req_bank, req_addr, -1, (k == 0) ? "R5" : "R6");
            @(negedge clk);
            req_valid = 1'b0;
            repeat (3) @(negedge clk);
        end

        // Continuous requests across several refreshes
        cont_phase = 1;
        begin
            bit prev_sent = 0;
            for (int i = 0; i < 150; i++) begin
                @(negedge clk);
                req_valid = 1'b1;
                req_op = 2'(i % 4);
                if (grant) begin
                    req_bank = 1'(i % 2); req_addr = 11'(i);
                    push(op_code(i % 4), req_bank, req_addr, prev_sent ? 1 : -1, "R6");
                    prev_sent = 1;
                end else begin
                    req_bank = 1'b1; req_addr = 11'h7FF;  // must never reach pins
                    prev_sent = 0;
                end
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        cont_phase = 0;

        // Idle: refresh keeps running
        repeat (130) @(negedge clk);
        chk(q.size() == 0, "R6", "granted requests left unissued", q.size(), 0);
        chk(n_run_refs >= 6, "R7", "periodic refresh count", n_run_refs, 6);
        chk(init_done, "R4", "init_done still high", init_done, 1);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end
endmodule